// File: doc/BRIEF.md
# Mailbox Command Port Error Monitor

This block sits between user logic and a command/response mailbox. User logic pushes command words, each tagged with start-of-packet and end-of-packet flags, into a command FIFO that the mailbox drains. The mailbox pushes response words into a response FIFO that user logic drains. While words are accepted, the block checks each packet's framing against the argument count carried in its header word. It also runs a watchdog that fires if a packet stalls before its end marker arrives.

Misuse of the port is recorded as a sticky fatal error. There are four kinds: a push into a full command FIFO, a pop from an empty response FIFO, a framing mismatch, and a missing or late end marker. The first error discards every pending response. From then on the block accepts no new response and no new command word. Only a reset held for a minimum number of consecutive cycles clears it. A 32-bit read-only status word carries two live FIFO flags and the four error flags. An enable mask selects which status bits drive a single interrupt line, so software can poll the status word or wait for the interrupt.

Top module: `mbx_err_monitor`

## Requirements
- R1: After an effective reset, every error flag and every enable bit is 0. Status therefore reads 0x00000002: responses empty and command room available. The interrupt output is 0 and no command word is offered to the mailbox.
- R2: Status bit 0 is 1 exactly when the response FIFO holds at least one word. Responses leave in arrival order, and the head word is shown on `rsp_data` before it is popped.
- R3: Status bit 1 is 1 exactly when the command FIFO has room. A push while it is full is dropped, and it sets sticky status bit 8.
- R4: A pop request while the response FIFO is empty sets sticky status bit 9.
- R5: Sticky status bit 3 is set by any framing mismatch. A header is a word flagged start-of-packet, and its bits [11:0] give the count N of argument words that follow. The mismatch cases are:
  - a non-header word arriving outside a packet;
  - a header arriving inside an open packet;
  - an end flag on a word that is not the N-th argument;
  - an end flag on a header whose N is not 0.
- R6: Sticky status bit 4 is set in the cycle when a packet's final word is accepted without an end flag. The final word is the N-th argument, or the header itself when N is 0.
- R7: Sticky status bit 4 is also set when a packet is open and EOP_TIMEOUT consecutive cycles pass with no accepted command word. The count restarts on every accepted word.
- R8: Once any error flag is set, the response FIFO is empty, and in the same cycle status bit 0 reads 0. Responses offered by the mailbox are discarded, command pushes are not enqueued, and the error flags stay set until an effective reset.
- R9: A reset takes effect only on the RST_MIN-th consecutive cycle with `rst` high. A shorter pulse leaves all state untouched.
- R10: Status bit 2 and bits 31:10 always read 0.
- R11: `irq` is the OR of status ANDed with the enable mask. A write on `irq_en_data` keeps only the defined status bit positions (0, 1, 3, 4, 8 and 9).
- R12: Accepted command words reach the mailbox side in push order, with their data and both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset request; must be held RST_MIN cycles |
| cmd_wr | input | 1 | Push a command word |
| cmd_sop | input | 1 | Pushed word is a packet header |
| cmd_eop | input | 1 | Pushed word closes the packet |
| cmd_data | input | 32 | Command word; header bits [11:0] hold the argument count |
| rsp_rd | input | 1 | Pop the head response word |
| rsp_data | output | 32 | Head response word |
| irq_en_wr | input | 1 | Load the interrupt enable mask |
| irq_en_data | input | 32 | New enable mask |
| status | output | 32 | Read-only status word |
| irq | output | 1 | Interrupt line |
| mb_cmd_rd | input | 1 | Mailbox pops the head command word |
| mb_cmd_valid | output | 1 | A command word is waiting for the mailbox |
| mb_cmd_sop | output | 1 | Head command word is a header |
| mb_cmd_eop | output | 1 | Head command word closes its packet |
| mb_cmd_data | output | 32 | Head command word |
| mb_rsp_wr | input | 1 | Mailbox pushes a response word |
| mb_rsp_data | input | 32 | Response word from the mailbox |
| mb_rsp_full | output | 1 | Response FIFO is full |

## Verification
Several properties are checked on every cycle: that reserved bits stay zero, that an overflowing push or an underflowing pop is always followed by its flag, that error flags stay set, that responses are discarded while an error is set, that the interrupt equals the masked status, and that an effective reset clears the flags. Other behaviour can only be shown by the bench's scenarios. These are the framing rules, with their separate early-end, stray-word, nested-header and missing-end cases, and the exact cycle in which the watchdog fires. They also include the rule that a nine-cycle reset pulse changes nothing while a ten-cycle pulse clears everything, and the ordering of command and response words through their FIFOs, which a scoreboard checks.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int STAT_W    = 32;
    localparam int WORD_W    = 32;
    localparam int HDR_LEN_W = 12;

    localparam int B_RSP_AVAIL = 0;
    localparam int B_CMD_ROOM  = 1;
    localparam int B_LEN_BAD   = 3;
    localparam int B_EOP_LATE  = 4;
    localparam int B_CMD_OVF   = 8;
    localparam int B_RSP_UDF   = 9;

    localparam logic [STAT_W-1:0] STAT_DEFINED = 32'h0000_031B;
    localparam logic [STAT_W-1:0] STAT_ERRORS  = 32'h0000_0318;

    typedef struct packed {
        logic rsp_udf;
        logic cmd_ovf;
        logic eop_late;
        logic len_bad;
    } mbx_err_t;

    typedef struct packed {
        logic              sop;
        logic              eop;
        logic [WORD_W-1:0] data;
    } mbx_cmd_word_t;

    typedef enum logic {
        PKT_IDLE = 1'b0,
        PKT_BODY = 1'b1
    } pkt_state_e;

    function automatic logic [STAT_W-1:0] pack_status(input mbx_err_t e,
                                                      input logic rsp_avail,
                                                      input logic cmd_room);
        logic [STAT_W-1:0] s;
        s              = '0;
        s[B_RSP_AVAIL] = rsp_avail;
        s[B_CMD_ROOM]  = cmd_room;
        s[B_LEN_BAD]   = e.len_bad;
        s[B_EOP_LATE]  = e.eop_late;
        s[B_CMD_OVF]   = e.cmd_ovf;
        s[B_RSP_UDF]   = e.rsp_udf;
        return s;
    endfunction

endpackage

// File: rtl/mbx_rst_qual.sv
module mbx_rst_qual #(
    parameter int RST_MIN = 10
) (
    input  logic clk,
    input  logic rst,
    output logic rst_eff
);
    localparam int CW = $clog2(RST_MIN + 1);

    logic [CW-1:0] held;

    // Counts consecutive cycles with the request high; cleared whenever it drops.
    always_ff @(posedge clk) begin
        if (!rst) begin
            held <= '0;
        end else if (held != CW'(RST_MIN)) begin
            held <= held + 1'b1;
        end
    end

    assign rst_eff = rst && (held >= CW'(RST_MIN - 1));

endmodule

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [W-1:0]    mem [DEPTH];
    logic [AW-1:0]   wp;
    logic [AW-1:0]   rp;
    logic [CNTW-1:0] cnt;
    logic            do_push;
    logic            do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNTW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush && !rst) begin
            mem[wp] <= wdata;
        end
    end

endmodule

// File: rtl/mbx_pkt_check.sv
module mbx_pkt_check
    import mbx_pkg::*;
#(
    parameter int EOP_TIMEOUT = 64,
    parameter int LEN_W       = HDR_LEN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             halt,
    input  logic             acc,
    input  logic             sop,
    input  logic             eop,
    input  logic [LEN_W-1:0] hdr_len,
    output logic             len_bad,
    output logic             eop_late
);
    localparam int TW = $clog2(EOP_TIMEOUT + 1);

    pkt_state_e       state, state_n;
    logic [LEN_W-1:0] remain, remain_n;
    logic [TW-1:0]    idle_cnt;
    logic             expired;

    assign expired = (state == PKT_BODY) && !halt && (idle_cnt == TW'(EOP_TIMEOUT - 1));

    always_comb begin
        state_n  = state;
        remain_n = remain;
        len_bad  = 1'b0;
        eop_late = 1'b0;
        if (acc) begin
            case (state)
                PKT_IDLE: begin
                    if (!sop) begin
                        len_bad = 1'b1;
                    end else if (eop) begin
                        len_bad = (hdr_len != '0);
                    end else if (hdr_len == '0) begin
                        eop_late = 1'b1;
                    end else begin
                        state_n  = PKT_BODY;
                        remain_n = hdr_len;
                    end
                end
                default: begin
                    if (sop) begin
                        len_bad = 1'b1;
                    end else if (eop) begin
                        len_bad = (remain != LEN_W'(1));
                        state_n = PKT_IDLE;
                    end else if (remain == LEN_W'(1)) begin
                        eop_late = 1'b1;
                        state_n  = PKT_IDLE;
                    end else begin
                        remain_n = remain - 1'b1;
                    end
                end
            endcase
        end else if (expired) begin
            eop_late = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= PKT_IDLE;
            remain <= '0;
        end else begin
            state  <= state_n;
            remain <= remain_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || acc) begin
            idle_cnt <= '0;
        end else if (state == PKT_BODY && !halt && idle_cnt != TW'(EOP_TIMEOUT)) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mbx_err_monitor.sv
module mbx_err_monitor
    import mbx_pkg::*;
#(
    parameter int CMD_DEPTH   = 8,
    parameter int RSP_DEPTH   = 8,
    parameter int EOP_TIMEOUT = 64,
    parameter int RST_MIN     = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic              cmd_sop,
    input  logic              cmd_eop,
    input  logic [WORD_W-1:0] cmd_data,
    input  logic              rsp_rd,
    output logic [WORD_W-1:0] rsp_data,
    input  logic              irq_en_wr,
    input  logic [STAT_W-1:0] irq_en_data,
    output logic [STAT_W-1:0] status,
    output logic              irq,
    input  logic              mb_cmd_rd,
    output logic              mb_cmd_valid,
    output logic              mb_cmd_sop,
    output logic              mb_cmd_eop,
    output logic [WORD_W-1:0] mb_cmd_data,
    input  logic              mb_rsp_wr,
    input  logic [WORD_W-1:0] mb_rsp_data,
    output logic              mb_rsp_full
);
    localparam int CMD_W = $bits(mbx_cmd_word_t);

    logic              rst_eff;
    logic              cmd_full, cmd_empty;
    logic              rsp_empty;
    logic              cmd_acc;
    logic              rsp_flush;
    logic              err_any, err_set;
    mbx_err_t          err_q, err_ev;
    logic [STAT_W-1:0] irq_en_q;
    mbx_cmd_word_t     cmd_in, cmd_head;

    mbx_rst_qual #(.RST_MIN(RST_MIN)) u_rst (
        .clk     (clk),
        .rst     (rst),
        .rst_eff (rst_eff)
    );

    assign err_any = |err_q;
    assign cmd_acc = cmd_wr && !cmd_full && !err_any;
    assign cmd_in  = '{sop: cmd_sop, eop: cmd_eop, data: cmd_data};

    mbx_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmd_fifo (
        .clk   (clk),
        .rst   (rst_eff),
        .flush (1'b0),
        .push  (cmd_acc),
        .wdata (cmd_in),
        .pop   (mb_cmd_rd),
        .rdata (cmd_head),
        .empty (cmd_empty),
        .full  (cmd_full)
    );

    mbx_pkt_check #(.EOP_TIMEOUT(EOP_TIMEOUT), .LEN_W(HDR_LEN_W)) u_pkt (
        .clk      (clk),
        .rst      (rst_eff),
        .halt     (err_any),
        .acc      (cmd_acc),
        .sop      (cmd_sop),
        .eop      (cmd_eop),
        .hdr_len  (cmd_data[HDR_LEN_W-1:0]),
        .len_bad  (err_ev.len_bad),
        .eop_late (err_ev.eop_late)
    );

    assign err_ev.cmd_ovf = cmd_wr && cmd_full;
    assign err_ev.rsp_udf = rsp_rd && rsp_empty;
    assign err_set        = |err_ev;
    assign rsp_flush      = err_any || err_set;

    mbx_fifo #(.W(WORD_W), .DEPTH(RSP_DEPTH)) u_rsp_fifo (
        .clk   (clk),
        .rst   (rst_eff),
        .flush (rsp_flush),
        .push  (mb_rsp_wr),
        .wdata (mb_rsp_data),
        .pop   (rsp_rd),
        .rdata (rsp_data),
        .empty (rsp_empty),
        .full  (mb_rsp_full)
    );

    always_ff @(posedge clk) begin
        if (rst_eff) begin
            err_q <= '0;
        end else begin
            err_q <= mbx_err_t'(err_q | err_ev);
        end
    end

    always_ff @(posedge clk) begin
        if (rst_eff) begin
            irq_en_q <= '0;
        end else if (irq_en_wr) begin
            irq_en_q <= irq_en_data & STAT_DEFINED;
        end
    end

    assign status       = pack_status(err_q, !rsp_empty, !cmd_full);
    assign irq          = |(status & irq_en_q);
    assign mb_cmd_valid = !cmd_empty;
    assign mb_cmd_sop   = cmd_head.sop;
    assign mb_cmd_eop   = cmd_head.eop;
    assign mb_cmd_data  = cmd_head.data;

endmodule

// File: rtl/mbx_err_monitor_chk.sv
module mbx_err_monitor_chk
    import mbx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rst_eff,
    input logic              cmd_wr,
    input logic              rsp_rd,
    input logic              irq_en_wr,
    input logic [STAT_W-1:0] irq_en_data,
    input logic [STAT_W-1:0] status,
    input logic              irq,
    input logic              mb_rsp_wr
);
    logic              armed = 1'b0;
    logic [STAT_W-1:0] en_shadow;

    always_ff @(posedge clk) begin
        if (rst_eff) armed <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst_eff)        en_shadow <= '0;
        else if (irq_en_wr) en_shadow <= irq_en_data & STAT_DEFINED;
    end

    p_reserved_zero_r10: assert property (@(posedge clk) disable iff (rst || !armed)
        (status & ~STAT_DEFINED) == '0);

    p_full_push_r3: assert property (@(posedge clk) disable iff (rst || !armed)
        (cmd_wr && !status[B_CMD_ROOM]) |=> status[B_CMD_OVF]);

    p_empty_pop_r4: assert property (@(posedge clk) disable iff (rst || !armed)
        (rsp_rd && !status[B_RSP_AVAIL]) |=> status[B_RSP_UDF]);

    p_sticky_r8: assert property (@(posedge clk) disable iff (rst || !armed)
        (|(status & STAT_ERRORS)) |=>
            ((status & $past(status) & STAT_ERRORS) == ($past(status) & STAT_ERRORS)));

    p_flushed_r8: assert property (@(posedge clk) disable iff (rst || !armed)
        (|(status & STAT_ERRORS)) |-> !status[B_RSP_AVAIL]);

    p_rsp_blocked_r8: assert property (@(posedge clk) disable iff (rst || !armed)
        ((|(status & STAT_ERRORS)) && mb_rsp_wr) |=> !status[B_RSP_AVAIL]);

    p_irq_mask_r11: assert property (@(posedge clk) disable iff (rst || !armed)
        irq == |(status & en_shadow));

    p_reset_clears_r9: assert property (@(posedge clk) disable iff (!armed)
        rst_eff |=> ((status & STAT_ERRORS) == '0) && !irq);

endmodule

bind mbx_err_monitor mbx_err_monitor_chk u_chk (.*);

// File: tb/mbx_err_monitor_test.sv
module mbx_err_monitor_test;
    import mbx_pkg::*;

    localparam int CMD_DEPTH = 4;
    localparam int RSP_DEPTH = 4;
    localparam int EOP_T     = 16;
    localparam int RST_MIN   = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b0;
    logic        cmd_wr = 1'b0, cmd_sop = 1'b0, cmd_eop = 1'b0;
    logic [31:0] cmd_data = '0;
    logic        rsp_rd = 1'b0;
    logic [31:0] rsp_data;
    logic        irq_en_wr = 1'b0;
    logic [31:0] irq_en_data = '0;
    logic [31:0] status;
    logic        irq;
    logic        mb_cmd_rd = 1'b0;
    logic        mb_cmd_valid, mb_cmd_sop, mb_cmd_eop;
    logic [31:0] mb_cmd_data;
    logic        mb_rsp_wr = 1'b0;
    logic [31:0] mb_rsp_data = '0;
    logic        mb_rsp_full;

    int checks = 0;
    int errors = 0;
    bit mon_en = 1'b0;
    mbx_cmd_word_t cmd_q[$];
    logic [31:0]   rsp_q[$];

    always #5 clk = ~clk;

    mbx_err_monitor #(.CMD_DEPTH(CMD_DEPTH), .RSP_DEPTH(RSP_DEPTH),
                      .EOP_TIMEOUT(EOP_T), .RST_MIN(RST_MIN)) uut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_sop(cmd_sop), .cmd_eop(cmd_eop),
        .cmd_data(cmd_data), .rsp_rd(rsp_rd), .rsp_data(rsp_data),
        .irq_en_wr(irq_en_wr), .irq_en_data(irq_en_data), .status(status), .irq(irq),
        .mb_cmd_rd(mb_cmd_rd), .mb_cmd_valid(mb_cmd_valid), .mb_cmd_sop(mb_cmd_sop),
        .mb_cmd_eop(mb_cmd_eop), .mb_cmd_data(mb_cmd_data), .mb_rsp_wr(mb_rsp_wr),
        .mb_rsp_data(mb_rsp_data), .mb_rsp_full(mb_rsp_full)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hold_reset(input int n);
        rst = 1'b1;
        repeat (n) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // Driver: the expected word enters the scoreboard before it can reach the mailbox side.
    task automatic send(input logic sop, input logic eop, input logic [31:0] d, input bit enq);
        cmd_wr = 1'b1; cmd_sop = sop; cmd_eop = eop; cmd_data = d;
        if (enq) cmd_q.push_back('{sop: sop, eop: eop, data: d});
        @(negedge clk);
        cmd_wr = 1'b0; cmd_sop = 1'b0; cmd_eop = 1'b0;
    endtask

    task automatic rsp_put(input logic [31:0] d, input bit keep);
        mb_rsp_wr = 1'b1; mb_rsp_data = d;
        if (keep) rsp_q.push_back(d);
        @(negedge clk);
        mb_rsp_wr = 1'b0;
    endtask

    task automatic rsp_get();
        logic [31:0] exp;
        exp = (rsp_q.size() > 0) ? rsp_q.pop_front() : 32'hDEAD_BEEF;
        chk("R2 response order", rsp_data, exp);
        rsp_rd = 1'b1;
        @(negedge clk);
        rsp_rd = 1'b0;
    endtask

    task automatic set_en(input logic [31:0] v);
        irq_en_wr = 1'b1; irq_en_data = v;
        @(negedge clk);
        irq_en_wr = 1'b0;
    endtask

    // Monitor: pops the mailbox side and compares against the scoreboard.
    initial begin
        mbx_cmd_word_t exp;
        forever begin
            @(negedge clk);
            if (mon_en && mb_cmd_valid) begin
                if (cmd_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R12 unexpected word actual=%0h expected=none", mb_cmd_data);
                end else begin
                    exp = cmd_q.pop_front();
                    chk("R12 command word", {mb_cmd_sop, mb_cmd_eop, mb_cmd_data},
                        {exp.sop, exp.eop, exp.data});
                end
                mb_cmd_rd = 1'b1;
            end else begin
                mb_cmd_rd = 1'b0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        hold_reset(RST_MIN + 2);
        chk("R1 status after reset", status, 32'h2);
        chk("R1 irq after reset", irq, 0);
        chk("R1 no command offered", mb_cmd_valid, 0);

        // Well-formed packets
        mon_en = 1'b1;
        send(1, 0, 32'h0000_0002, 1);
        send(0, 0, 32'hA5A5_0001, 1);
        send(0, 1, 32'h5A5A_0002, 1);
        send(1, 1, 32'h0000_0000, 1);
        cycles(5);
        chk("R12 all words delivered", cmd_q.size(), 0);
        chk("R5 matched framing leaves no error", status, 32'h2);

        // Response path
        rsp_put(32'h0000_0011, 1);
        chk("R2 data valid set", status[0], 1);
        rsp_put(32'h0000_0022, 1);
        rsp_get();
        rsp_get();
        chk("R2 data valid clear", status[0], 0);

        // Interrupt mask
        set_en(32'h1);
        chk("R11 masked off", irq, 0);
        rsp_put(32'h0000_0033, 1);
        chk("R11 data valid raises irq", irq, 1);
        rsp_get();
        chk("R11 irq drops with status", irq, 0);
        set_en(32'hFFFF_FC04);
        chk("R11 reserved enable bits not kept", irq, 0);
        set_en(32'h2);
        chk("R11 room raises irq", irq, 1);
        set_en(32'h0);

        // Command FIFO overflow
        mon_en = 1'b0;
        send(1, 0, 32'h0000_0006, 1);
        send(0, 0, 32'h0000_0101, 1);
        send(0, 0, 32'h0000_0102, 1);
        send(0, 0, 32'h0000_0103, 1);
        chk("R3 full clears room", status, 32'h0);
        send(0, 0, 32'h0000_0104, 0);
        chk("R3 overflow flag", status, 32'h100);
        chk("R10 reserved zero", status & 32'hFFFF_FC04, 0);
        rsp_put(32'h0000_0044, 0);
        chk("R8 response discarded after error", status[0], 0);
        mon_en = 1'b1;
        cycles(8);
        chk("R12 pre-error words delivered", cmd_q.size(), 0);
        send(1, 1, 32'h0000_0000, 0);
        cycles(3);
        chk("R8 command dropped after error", mb_cmd_valid, 0);
        chk("R8 error stays set", status, 32'h102);

        // Reset length qualification
        hold_reset(RST_MIN - 1);
        chk("R9 short pulse ignored", status, 32'h102);
        hold_reset(RST_MIN);
        chk("R9 full reset clears", status, 32'h2);

        // Pop from empty response FIFO
        rsp_rd = 1'b1;
        @(negedge clk);
        rsp_rd = 1'b0;
        chk("R4 underflow flag", status, 32'h202);
        set_en(32'h200);
        chk("R11 error raises irq", irq, 1);
        hold_reset(RST_MIN);
        chk("R1 enable cleared by reset", irq, 0);

        // Stray word flushes pending responses
        rsp_put(32'h0000_0055, 0);
        rsp_put(32'h0000_0066, 0);
        chk("R2 responses pending", status[0], 1);
        send(0, 1, 32'h0000_0077, 1);
        chk("R8 flush on stray word error", status, 32'h0A);
        cycles(3);
        hold_reset(RST_MIN);

        // Early end flag
        send(1, 0, 32'h0000_0003, 1);
        send(0, 0, 32'h0000_0201, 1);
        send(0, 1, 32'h0000_0202, 1);
        chk("R5 early end flag", status[3], 1);
        cycles(3);
        hold_reset(RST_MIN);

        // Header inside open packet
        send(1, 0, 32'h0000_0002, 1);
        send(1, 0, 32'h0000_0002, 1);
        chk("R5 nested header", status[3], 1);
        cycles(3);
        hold_reset(RST_MIN);

        // Header with non-zero count carrying end flag
        send(1, 1, 32'h0000_0001, 1);
        chk("R5 end flag on counted header", status[3], 1);
        cycles(3);
        hold_reset(RST_MIN);

        // Final argument without end flag
        send(1, 0, 32'h0000_0001, 1);
        send(0, 0, 32'h0000_0301, 1);
        chk("R6 final argument lacks end", status & 32'h318, 32'h10);
        cycles(3);
        hold_reset(RST_MIN);

        send(1, 0, 32'h0000_0000, 1);
        chk("R6 empty header lacks end", status & 32'h318, 32'h10);
        cycles(3);
        hold_reset(RST_MIN);

        // End-of-packet watchdog
        set_en(32'h10);
        send(1, 0, 32'h0000_0003, 1);
        send(0, 0, 32'h0000_0401, 1);
        cycles(EOP_T - 1);
        chk("R7 no timeout one cycle early", status[4], 0);
        chk("R7 irq quiet before timeout", irq, 0);
        cycles(1);
        chk("R7 timeout flag", status[4], 1);
        chk("R7 timeout irq", irq, 1);
        chk("R10 reserved zero after timeout", status & 32'hFFFF_FC04, 0);

        cycles(4);
        chk("R12 scoreboard drained", cmd_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule